// File: doc/BRIEF.md
# Zero-Event Interrupt Mask Counter

This block sits between a timer's zero-detect strobe and the interrupt flag that the strobe would normally set. It lets only one zero event in every N+1 through, where N is a programmable 4-bit mask count. A down-counter tracks how many more events are still to be swallowed. When an event arrives while that counter is at 0, the block issues a one-cycle flag-set pulse and reloads the counter.

Software controls the block with a single register write. The write carries an enable bit and a new mask count. While masking is off, a new count takes effect at once. While masking is on, the count that is running cannot be changed directly. The new count waits in a buffer and replaces the running one at the next reload. Every write also restarts the counter at once from the running count.

A mask count of 0 disables suppression. With the enable bit cleared, every zero event goes through. A zero condition seen when the timer starts at 0 is handled like any other zero event and uses up one count.

Top module: `zmask_top`

## Requirements
- R1: After reset the enable, the running count, the buffered count and the counter are all 0, and `zero_flag_set` is 0.
- R2: While the enable is 0, every zero event produces a `zero_flag_set` pulse in the cycle after the event.
- R3: While the enable is 1 and the counter is above 0, a zero event decrements the counter by one and produces no pulse.
- R4: While the enable is 1 and the counter is 0, a zero event produces a pulse. It also copies the buffered count into both the running count and the counter.
- R5: A write while the enable is 0 loads the written count into the buffer, the running count and the counter, and it loads the written enable bit.
- R6: A write while the enable is 1 loads the written count into the buffer only. The counter restarts from the running count that was in force before the write. The written count is used from the next reload on.
- R7: With the enable at 1 and a running count of 0, every zero event produces a pulse.
- R8: `zero_flag_set` is high for exactly one cycle, and only in the cycle after a sampled zero event.
- R9: When a write and a zero event come in the same cycle, the pulse is decided from the state before the write, and the counter takes the value that the write loads.
- R10: With a running count N, a steady train of zero events produces a pulse on every (N+1)-th event, counting from the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zero_evt | input | 1 | One-cycle strobe: the timer reached zero |
| mask_wr | input | 1 | Write strobe for the mask control register |
| mask_wr_enable | input | 1 | Enable bit carried by the write |
| mask_wr_count | input | CNT_W | Mask count carried by the write |
| zero_flag_set | output | 1 | One-cycle pulse that sets the zero interrupt flag |

## Verification
Every result appears exactly one cycle after its cause. A zero event sampled on a rising edge gives its pulse right after that edge. A write changes the counter on the same edge, so its effect shows up in the pulse pattern of the events that follow. The bench drives each stimulus at a falling edge for one cycle and samples `zero_flag_set` at the next falling edge, half a cycle after the edge that registered the pulse. Expected patterns come from the modulo rule of R10 for all sixteen mask counts. Fixed, hand-derived sequences cover the buffered-write and same-cycle cases.

// File: rtl/zmask_pkg.sv
package zmask_pkg;

    // Counter action chosen each cycle; the reload path in the config
    // block listens for ACT_RELOAD.
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_DEC    = 2'd1,
        ACT_RELOAD = 2'd2,
        ACT_WRLOAD = 2'd3
    } cnt_act_e;

endpackage

// File: rtl/zmask_cfg.sv
module zmask_cfg #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_mask_en,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             reload_take,
    output logic             en_q,
    output logic [CNT_W-1:0] buf_q,
    output logic [CNT_W-1:0] wr_load
);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic en;
        cnt_t act;
        cnt_t bufv;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.en   = wr_mask_en;
            st_d.bufv = wr_cnt;
            if (!st_q.en) begin
                st_d.act = wr_cnt;
            end
        end else if (reload_take) begin
            st_d.act = st_q.bufv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q    = st_q.en;
    assign buf_q   = st_q.bufv;
    assign wr_load = st_q.en ? st_q.act : wr_cnt;

    AST_ACTIVE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_q.en) |=> (st_q.act == $past(st_q.act))); // R6
    AST_ACTIVE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !st_q.en) |=> (st_q.act == $past(wr_cnt))); // R5
    AST_BUFFER_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.bufv == $past(wr_cnt))); // R6

endmodule

// File: rtl/zmask_ctr.sv
module zmask_ctr
    import zmask_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_evt,
    input  logic             wr_en,
    input  logic             en,
    input  logic [CNT_W-1:0] wr_load,
    input  logic [CNT_W-1:0] buf_val,
    output cnt_act_e         act,
    output logic             flag_set
);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t cnt;
        logic flag;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        if (wr_en) begin
            act = ACT_WRLOAD;
        end else if (zero_evt && en) begin
            act = (st_q.cnt == '0) ? ACT_RELOAD : ACT_DEC;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_comb begin
        st_d = st_q;
        st_d.flag = zero_evt && (!en || (st_q.cnt == '0));
        unique case (act)
            ACT_WRLOAD: st_d.cnt = wr_load;
            ACT_RELOAD: st_d.cnt = buf_val;
            ACT_DEC:    st_d.cnt = st_q.cnt - cnt_t'(1);
            default:    st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_set = st_q.flag;

    AST_OFF_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && !en) |=> flag_set); // R2
    AST_MASK_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && en && st_q.cnt != '0 && !wr_en) |=>
        (!flag_set && st_q.cnt == cnt_t'($past(st_q.cnt) - cnt_t'(1)))); // R3
    AST_ZERO_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && en && st_q.cnt == '0 && !wr_en) |=>
        (flag_set && st_q.cnt == $past(buf_val))); // R4
    AST_PULSE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_evt |=> !flag_set); // R8

endmodule

// File: rtl/zmask_top.sv
module zmask_top
    import zmask_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_evt,
    input  logic             mask_wr,
    input  logic             mask_wr_enable,
    input  logic [CNT_W-1:0] mask_wr_count,
    output logic             zero_flag_set
);

    logic             en_q;
    logic [CNT_W-1:0] buf_q;
    logic [CNT_W-1:0] wr_load;
    cnt_act_e         act;

    zmask_cfg #(.CNT_W(CNT_W)) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (mask_wr),
        .wr_mask_en  (mask_wr_enable),
        .wr_cnt      (mask_wr_count),
        .reload_take (act == ACT_RELOAD),
        .en_q        (en_q),
        .buf_q       (buf_q),
        .wr_load     (wr_load)
    );

    zmask_ctr #(.CNT_W(CNT_W)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_evt (zero_evt),
        .wr_en    (mask_wr),
        .en       (en_q),
        .wr_load  (wr_load),
        .buf_val  (buf_q),
        .act      (act),
        .flag_set (zero_flag_set)
    );

    AST_SAME_CYCLE_PRESTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && zero_evt && !en_q) |=> zero_flag_set); // R9

endmodule

// File: tb/test_zmask_top.sv
module test_zmask_top;

    localparam int unsigned CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             zero_evt = 1'b0;
    logic             mask_wr = 1'b0;
    logic             mask_wr_enable = 1'b0;
    logic [CNT_W-1:0] mask_wr_count = '0;
    logic             zero_flag_set;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    zmask_top #(.CNT_W(CNT_W)) i_zmask_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .zero_evt       (zero_evt),
        .mask_wr        (mask_wr),
        .mask_wr_enable (mask_wr_enable),
        .mask_wr_count  (mask_wr_count),
        .zero_flag_set  (zero_flag_set)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: zero_flag_set=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // one zero event, then sample the pulse half a cycle after it registers
    task automatic evt(input logic exp, input string req);
        @(negedge clk);
        zero_evt = 1'b1;
        @(negedge clk);
        zero_evt = 1'b0;
        chk(zero_flag_set, exp, req);
    endtask

    task automatic wr(input logic en, input int cnt);
        @(negedge clk);
        mask_wr = 1'b1;
        mask_wr_enable = en;
        mask_wr_count = CNT_W'(cnt);
        @(negedge clk);
        mask_wr = 1'b0;
        chk(zero_flag_set, 1'b0, "R8 no pulse after write");
    endtask

    task automatic wr_evt(input logic en, input int cnt, input logic exp, input string req);
        @(negedge clk);
        mask_wr = 1'b1;
        mask_wr_enable = en;
        mask_wr_count = CNT_W'(cnt);
        zero_evt = 1'b1;
        @(negedge clk);
        mask_wr = 1'b0;
        zero_evt = 1'b0;
        chk(zero_flag_set, exp, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(zero_flag_set, 1'b0, "R1 reset flag");
        @(negedge clk);
        chk(zero_flag_set, 1'b0, "R8 idle stays low");

        // R1/R2: after reset the enable is 0, so every event passes
        for (int k = 0; k < 5; k++) evt(1'b1, "R2 disabled pass (R1 reset enable)");

        // R10 sweep over every mask count, direct writes while disabled (R5)
        for (int n = 0; n < 16; n++) begin
            wr(1'b0, 0);
            wr(1'b1, n);
            for (int k = 0; k < 2 * (n + 1) + 1; k++) begin
                evt(((k % (n + 1)) == n) ? 1'b1 : 1'b0,
                    (n == 0) ? "R7 zero count passes all" :
                    (((k % (n + 1)) == n) ? "R4 pass at zero (R10)" : "R3 masked (R10, R5)"));
            end
            wr(1'b0, 0);
            for (int k = 0; k < 2; k++) evt(1'b1, "R2 disabled after sweep");
        end

        // R6 buffered write while masking: running 2, buffer 5
        wr(1'b1, 2);
        evt(1'b0, "R3 first masked");
        wr(1'b1, 5);
        evt(1'b0, "R6 restart from old count");
        evt(1'b0, "R6 restart from old count");
        evt(1'b1, "R6 old count still governs");
        for (int k = 0; k < 5; k++) evt(1'b0, "R6 new count after reload");
        evt(1'b1, "R6 new count pass");

        // R9 same-cycle write and event
        wr(1'b0, 0);
        wr(1'b1, 3);
        wr_evt(1'b1, 1, 1'b0, "R9 masked by pre-write state");
        for (int k = 0; k < 3; k++) evt(1'b0, "R9 counter reloaded from 3");
        evt(1'b1, "R9 pass after restart");
        evt(1'b0, "R9 buffered 1 after reload");
        evt(1'b1, "R9 buffered 1 pass");
        wr(1'b0, 0);
        wr_evt(1'b1, 2, 1'b1, "R9 disabled pre-write passes");
        evt(1'b0, "R9 direct count 2");
        evt(1'b0, "R9 direct count 2");
        evt(1'b1, "R9 direct count 2 pass");

        // R8 pulse lasts one cycle only
        evt(1'b0, "R8 setup");
        evt(1'b0, "R8 setup");
        @(negedge clk);
        zero_evt = 1'b1;
        @(negedge clk);
        zero_evt = 1'b0;
        chk(zero_flag_set, 1'b1, "R8 pulse present");
        @(negedge clk);
        chk(zero_flag_set, 1'b0, "R8 pulse single cycle");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule